// File: doc/BRIEF.md
# Passive serial configuration loader

This block sits on the host side of a serial configuration link and loads a bitstream into a slave device. On a start pulse it drives the active-low request line low for a minimum time. It waits for the slave to acknowledge by pulling its status line and its loaded line low, then releases the request. It then waits for status to return high, under a timeout, and lets a settling interval pass. After that it shifts the bitstream out one bit per rising edge of a generated data clock. When the slave raises its loaded line, the block keeps toggling the clock for a fixed number of initialization cycles and then reports done.

All timing comes from the system clock through parameterized cycle counters. The data clock is the system clock divided by an even factor, and it pauses low while no byte is waiting. Bitstream bytes arrive on a valid/ready stream. The block raises `s_ready` only while it is in the data phase and its shift register is empty. A byte moves on any clock edge where `s_valid` and `s_ready` are both high. The source must hold `s_valid` and `s_data` steady until that edge, and it may keep `s_valid` high for as long as `s_ready` stays low. The status and loaded inputs are asynchronous and pass through synchronizers of `SYNC_STAGES` flops. The outputs `busy`, `ld_done` and `ld_error` report progress.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset, `cfg_req_n` is 1, `cfg_dclk` is 0, and `busy`, `ld_done`, `ld_error` and `s_ready` are all 0.
- R2: A start pulse from idle, done or error drives `cfg_req_n` low for at least `REQ_CYC` cycles. The request is released only after the synchronized status and loaded lines have both been seen low. If they have not been seen low when `ACK_CYC` cycles have passed, the block enters error and releases the request early.
- R3: With status monitoring on, status staying low after release is not an error until `ST_TO_CYC` cycles have passed. Past that point the block enters error without producing a single data clock edge.
- R4: The first rising data clock edge comes at least `ST2CK_CYC` cycles after status returns high. With monitoring off, it comes at least `CF2CK_CYC` cycles after the request is released.
- R5: Every high phase and every low phase of `cfg_dclk` lasts at least `DIV/2` system cycles, except when error cuts a phase short. `cfg_data` changes only while `cfg_dclk` is low.
- R6: Each accepted byte is sent least significant bit first, one bit per rising edge, and in the order the bytes were accepted.
- R7: `s_ready` is 1 only in the data phase with the shift register empty, and never while `cfg_dclk` is high. While no byte is available, `cfg_dclk` stays low and produces no edges.
- R8: Once the loaded line is seen high in the data phase, no more bytes are accepted. After exactly `INIT_CYC` further rising edges, the block sets `ld_done`, clears `busy` and leaves `cfg_dclk` low.
- R9: With monitoring on, status going low in the data or initialization phase sets `ld_error`, clears `busy` and stops `cfg_dclk` low.
- R10: `ld_done` and `ld_error` hold until the next start pulse, and a start pulse from either of them begins a new load.
- R11: `busy` is 1 from the request phase until the block enters done or error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a load |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | DW | Stream byte |
| s_ready | output | 1 | Block can take a byte |
| cfg_req_n | output | 1 | Active-low configuration request to the slave |
| cfg_status_n | input | 1 | Active-low status from the slave |
| cfg_loaded | input | 1 | Slave reports the bitstream is complete |
| cfg_dclk | output | 1 | Generated data clock |
| cfg_data | output | 1 | Serial data, valid at rising `cfg_dclk` |
| busy | output | 1 | Load in progress |
| ld_done | output | 1 | Load finished |
| ld_error | output | 1 | Load failed |

## Verification
The assertions assume that the error path is the only thing that may shorten the request pulse or a clock phase. They also assume that the loaded line rises only while the data clock is stalled, so that every rise it observes belongs to the data phase or the initialization phase. The bench slave model acknowledges two cycles after the request falls, releases status 30 cycles after the request rises, and raises the loaded line only after the last byte has been clocked out and the clock has stopped. Stream bytes are driven at the falling system clock edge and held until accepted, so back-pressure is exercised without ever changing a byte that is on offer.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_SETTLE, ST_DATA, ST_INIT, ST_DONE, ST_ERR
  } ld_state_t;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (clr)                count <= '0;
    else if (inc && count != '1) count <= count + 1'b1;
  end
endmodule

// File: rtl/ps_cfg_clkgen.sv
module ps_cfg_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic dclk,
  output logic rise,
  output logic fall
);
  localparam int HALF = DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HW-1:0] LAST = HW'(HALF - 1);

  logic [HW-1:0] hc;
  logic          wrap;

  assign wrap = run && (hc == LAST);
  assign rise = wrap && !dclk;
  assign fall = wrap && dclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc   <= '0;
      dclk <= 1'b0;
    end else if (!run) begin
      hc   <= '0;
      dclk <= 1'b0;
    end else if (wrap) begin
      hc   <= '0;
      dclk <= !dclk;
    end else begin
      hc   <= hc + 1'b1;
    end
  end
endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  input  logic          adv,
  output logic          bit_out,
  output logic          has_bit
);
  localparam int CNTW = $clog2(DW + 1);

  logic [DW-1:0]   sh;
  logic [CNTW-1:0] left;

  assign s_ready = en && (left == '0);
  assign has_bit = (left != '0);
  assign bit_out = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      left <= '0;
    end else if (clr) begin
      left <= '0;
    end else if (s_valid && s_ready) begin
      sh   <= s_data;
      left <= CNTW'(DW);
    end else if (adv && has_bit) begin
      sh   <= sh >> 1;
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
  import ps_cfg_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2,
  parameter int REQ_CYC     = 100,
  parameter int ACK_CYC     = 30,
  parameter int ST_TO_CYC   = 75300,
  parameter int ST2CK_CYC   = 100,
  parameter int CF2CK_CYC   = 75300,
  parameter int INIT_CYC    = 17408,
  parameter bit MON_STATUS  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic          cfg_req_n,
  input  logic          cfg_status_n,
  input  logic          cfg_loaded,
  output logic          cfg_dclk,
  output logic          cfg_data,
  output logic          busy,
  output logic          ld_done,
  output logic          ld_error
);
  localparam int MAXC = max2(max2(max2(REQ_CYC, ACK_CYC), max2(ST_TO_CYC, ST2CK_CYC)),
                             max2(CF2CK_CYC, INIT_CYC));
  localparam int CW = $clog2(MAXC + 2);
  localparam logic [CW-1:0] L_REQ   = CW'(REQ_CYC - 1);
  localparam logic [CW-1:0] L_ACK   = CW'(ACK_CYC);
  localparam logic [CW-1:0] L_STTO  = CW'(ST_TO_CYC - 1);
  localparam logic [CW-1:0] L_ST2CK = CW'(ST2CK_CYC - 1);
  localparam logic [CW-1:0] L_CF2CK = CW'(CF2CK_CYC - 1);
  localparam logic [CW-1:0] L_INIT  = CW'(INIT_CYC);

  ld_state_t state, nxt;
  logic [SYNC_STAGES-1:0] st_sync, dn_sync;
  logic st_hi, loaded, ack_seen;
  logic [CW-1:0] tc;
  logic tmr_clr, tmr_inc;
  logic clk_run, rise, fall, has_bit;
  logic sh_en, sh_clr;

  // asynchronous slave lines enter through flop chains
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sync <= '1;
      dn_sync <= '0;
    end else begin
      st_sync <= {st_sync[SYNC_STAGES-2:0], cfg_status_n};
      dn_sync <= {dn_sync[SYNC_STAGES-2:0], cfg_loaded};
    end
  end
  assign st_hi  = st_sync[SYNC_STAGES-1];
  assign loaded = dn_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ack_seen <= 1'b0;
    else if (state != ST_REQ) ack_seen <= 1'b0;
    else if (!st_hi && !loaded) ack_seen <= 1'b1;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE, ST_DONE, ST_ERR: if (start) nxt = ST_REQ;
      ST_REQ: begin
        if (!ack_seen && tc == L_ACK)     nxt = ST_ERR;
        else if (ack_seen && tc >= L_REQ) nxt = ST_WAIT;
      end
      ST_WAIT: begin
        if (MON_STATUS) begin
          if (st_hi)             nxt = ST_SETTLE;
          else if (tc >= L_STTO) nxt = ST_ERR;
        end else if (tc >= L_CF2CK) begin
          nxt = ST_DATA;
        end
      end
      ST_SETTLE: begin
        if (!st_hi)             nxt = ST_ERR;
        else if (tc >= L_ST2CK) nxt = ST_DATA;
      end
      ST_DATA: begin
        if (MON_STATUS && !st_hi) nxt = ST_ERR;
        else if (loaded)          nxt = ST_INIT;
      end
      ST_INIT: begin
        if (MON_STATUS && !st_hi)     nxt = ST_ERR;
        else if (tc == L_INIT && fall) nxt = ST_DONE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // one counter serves every phase: cycles elsewhere, rising edges in init
  assign tmr_clr = (state != nxt);
  assign tmr_inc = (state == ST_INIT) ? rise : 1'b1;

  ps_cfg_timer #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc), .count(tc)
  );

  assign clk_run = ((state == ST_DATA) && has_bit) || (state == ST_INIT);

  ps_cfg_clkgen #(.DIV(DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(clk_run),
    .dclk(cfg_dclk), .rise(rise), .fall(fall)
  );

  assign sh_en  = (state == ST_DATA) && !loaded;
  assign sh_clr = (state != ST_DATA);

  ps_cfg_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .en(sh_en),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .adv(fall), .bit_out(cfg_data), .has_bit(has_bit)
  );

  assign cfg_req_n = (state != ST_REQ);
  assign busy      = (state == ST_REQ) || (state == ST_WAIT) || (state == ST_SETTLE) ||
                     (state == ST_DATA) || (state == ST_INIT);
  assign ld_done   = (state == ST_DONE);
  assign ld_error  = (state == ST_ERR);
endmodule

// File: rtl/ps_cfg_loader_chk.sv
module ps_cfg_loader_chk #(
  parameter int REQ_CYC = 100,
  parameter int DIV     = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_req_n,
  input logic cfg_dclk,
  input logic cfg_data,
  input logic s_ready,
  input logic busy,
  input logic ld_done,
  input logic ld_error
);
  localparam int HALF = DIV / 2;

  int unsigned lowrun, prun;
  logic dq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowrun <= 0;
      prun   <= 0;
      dq     <= 1'b0;
    end else begin
      lowrun <= !cfg_req_n ? ((lowrun < 32'hFFFF) ? lowrun + 1 : lowrun) : 0;
      dq     <= cfg_dclk;
      prun   <= (cfg_dclk != dq) ? 1 : ((prun < 32'hFFFF) ? prun + 1 : prun);
    end
  end

  a_r2_req_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_n && lowrun != 0) |-> (lowrun >= REQ_CYC || ld_error));

  a_r5_phase_min: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_dclk != dq) && !ld_error) |-> prun >= HALF);

  a_r5_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dclk && dq) |-> $stable(cfg_data));

  a_r7_ready_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && !cfg_dclk));

  a_r9_error_stops_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_error) |=> !cfg_dclk);

  a_r11_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ld_done || ld_error));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cfg_req_n && !s_ready));
endmodule

bind ps_cfg_loader ps_cfg_loader_chk #(.REQ_CYC(REQ_CYC), .DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_req_n(cfg_req_n), .cfg_dclk(cfg_dclk),
  .cfg_data(cfg_data), .s_ready(s_ready), .busy(busy),
  .ld_done(ld_done), .ld_error(ld_error)
);

// File: tb/ps_cfg_loader_tb.sv
module ps_cfg_loader_tb;
  localparam int DIV = 4, HALF = 2, REQ = 12, ACK = 8, STTO = 200;
  localparam int ST2CK = 8, INIT = 24, REL = 30;

  logic clk = 0, rst_n = 0, start = 0, s_valid = 0;
  logic [7:0] s_data = 0;
  logic s_ready, cfg_req_n, cfg_dclk, cfg_data, busy, ld_done, ld_error;
  logic nstat = 1, loaded = 0;

  always #10 clk = !clk;

  ps_cfg_loader #(.DW(8), .DIV(DIV), .SYNC_STAGES(2), .REQ_CYC(REQ), .ACK_CYC(ACK),
    .ST_TO_CYC(STTO), .ST2CK_CYC(ST2CK), .CF2CK_CYC(50), .INIT_CYC(INIT), .MON_STATUS(1'b1))
  u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .cfg_req_n(cfg_req_n), .cfg_status_n(nstat), .cfg_loaded(loaded),
    .cfg_dclk(cfg_dclk), .cfg_data(cfg_data), .busy(busy), .ld_done(ld_done),
    .ld_error(ld_error)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  int rx_bytes, nbits, rises, init_rises, first_rise, reqlow, runlen;
  bit in_init;
  logic [7:0] acc;
  logic dprev = 0, dataprev = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: rising edges, phase lengths, scoreboard pop
  always @(negedge clk) begin
    if (!rst_n) begin
      dprev = 0; runlen = 0;
    end else begin
      if (!cfg_req_n) reqlow++;
      if (cfg_dclk && dprev && cfg_data != dataprev)
        chk(0, "R5 data moved while clock high", cfg_data, dataprev);
      if (cfg_dclk != dprev) begin
        if (!ld_error) chk(runlen >= HALF, "R5 phase length", runlen, HALF);
        runlen = 0;
      end
      runlen++;
      if (cfg_dclk && !dprev) begin
        rises++;
        if (first_rise < 0) first_rise = cyc;
        if (in_init) init_rises++;
        else begin
          acc[nbits] = cfg_data;
          nbits++;
          if (nbits == 8) begin
            nbits = 0;
            rx_bytes++;
            if (exp_q.size() == 0) chk(0, "R6 unexpected byte", acc, -1);
            else begin
              logic [7:0] e;
              e = exp_q.pop_front();
              chk(acc == e, "R6 byte order and bit order", acc, e);
            end
          end
        end
      end
      dprev = cfg_dclk;
      dataprev = cfg_data;
    end
  end

  function automatic logic [7:0] pat(int i, int seed);
    if (seed == 0 && i < 4) begin
      case (i)
        0: return 8'h00;
        1: return 8'hFF;
        2: return 8'h01;
        default: return 8'h80;
      endcase
    end
    return 8'((i * 59 + seed * 17) ^ (i * 3));
  endfunction

  // driver: offer a byte, push its expectation, hold it until accepted
  task automatic send(logic [7:0] b, int gap);
    repeat (gap) @(negedge clk);
    s_valid = 1;
    s_data  = b;
    exp_q.push_back(b);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic arm();
    rx_bytes = 0; nbits = 0; rises = 0; init_rises = 0; first_rise = -1;
    reqlow = 0; in_init = 0;
    exp_q.delete();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic slave_ack();
    while (cfg_req_n) @(negedge clk);
    repeat (2) @(negedge clk);
    nstat = 0;
    loaded = 0;
    while (!cfg_req_n) @(negedge clk);
  endtask

  task automatic full_load(int n, int seed, int gapmod);
    int t_hi;
    t_hi = 0;
    arm();
    chk(busy == 1, "R11 busy after start", busy, 1);
    fork
      begin
        slave_ack();
        chk(reqlow >= REQ, "R2 request low width", reqlow, REQ);
        repeat (REL) @(negedge clk);
        nstat = 1;
        t_hi = cyc;
      end
      begin
        for (int i = 0; i < n; i++) send(pat(i, seed), (gapmod == 0) ? 0 : (i % gapmod) * 7);
      end
    join
    while (rx_bytes < n) @(negedge clk);
    chk(first_rise - t_hi >= ST2CK, "R4 first rise after status high", first_rise - t_hi, ST2CK);
    repeat (12) @(negedge clk);
    chk(rises == 8 * n, "R7 no edges while stalled", rises, 8 * n);
    loaded = 1;
    in_init = 1;
    for (int k = 0; k < 2000 && !ld_done; k++) @(negedge clk);
    chk(ld_done == 1, "R8 done after init edges", ld_done, 1);
    chk(init_rises == INIT, "R8 init edge count", init_rises, INIT);
    chk(busy == 0 && cfg_dclk == 0 && ld_error == 0, "R8 quiet after done",
        {busy, cfg_dclk, ld_error}, 0);
    chk(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({cfg_req_n, cfg_dclk, busy, ld_done, ld_error, s_ready} == 6'b100000,
        "R1 state in reset", {cfg_req_n, cfg_dclk, busy, ld_done, ld_error, s_ready}, 32);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({cfg_req_n, cfg_dclk, busy, ld_done, ld_error, s_ready} == 6'b100000,
        "R1 state after reset", {cfg_req_n, cfg_dclk, busy, ld_done, ld_error, s_ready}, 32);

    // back-to-back bytes with corner patterns
    full_load(10, 0, 0);
    repeat (20) @(negedge clk);
    chk(ld_done == 1 && cfg_req_n == 1, "R10 done holds", ld_done, 1);

    // no acknowledge from the slave
    nstat = 1;
    loaded = 1;
    arm();
    repeat (ACK + 12) @(negedge clk);
    chk(ld_error == 1, "R2 missing acknowledge", ld_error, 1);
    chk(busy == 0 && cfg_req_n == 1, "R2 request released on error", {busy, cfg_req_n}, 1);

    // status held low after release
    arm();
    slave_ack();
    repeat (STTO / 2) @(negedge clk);
    chk(ld_error == 0 && busy == 1, "R3 no error inside window", {ld_error, busy}, 1);
    repeat (STTO) @(negedge clk);
    chk(ld_error == 1, "R3 status timeout", ld_error, 1);
    chk(rises == 0, "R3 no clock edges", rises, 0);

    // status drops during the data phase
    arm();
    fork
      begin
        slave_ack();
        repeat (REL) @(negedge clk);
        nstat = 1;
      end
      begin
        send(8'h3C, 0);
        send(8'hC3, 0);
      end
    join
    while (rx_bytes < 1) @(negedge clk);
    nstat = 0;
    repeat (8) @(negedge clk);
    chk(ld_error == 1 && busy == 0, "R9 abort on status low", {ld_error, busy}, 2);
    begin
      int r0;
      r0 = rises;
      repeat (30) @(negedge clk);
      chk(rises == r0 && cfg_dclk == 0, "R9 clock stopped", rises - r0, 0);
    end
    chk(ld_error == 1, "R10 error holds", ld_error, 1);

    // restart from error with gaps between bytes
    nstat = 1;
    full_load(7, 3, 3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule